// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog for a small processor subsystem. A counter advances on ticks from a free-running oscillator that is independent of the system clock. If software lets the selected timeout elapse without issuing a clear strobe, the block emits a reset request. Software then restarts from the reset vector. The clear strobe stands in for the processor's watchdog-reset instruction.

One control register sets the timeout, the enable bit and a turn-off-enable (guard) bit. Turning the watchdog on is immediate. Turning it off needs two writes. The first write sets the guard bit. The second write must clear the enable bit while the guard is still open. Hardware closes the guard by itself a fixed number of system clock cycles after it was written. A single stray write therefore cannot switch the watchdog off.

The oscillator is represented by a level input, `osc_lvl`. Each change of that level, rising or falling, counts as one tick. The level is passed through a synchronizer into the system clock domain. The analog oscillator and the wider reset sequencing are outside this block.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `rd_data` reads 0x00 (watchdog disabled, guard closed, period code 0) and `rst_req` is low.
- R2: Register layout: bits [2:0] hold the period code, bit 3 the enable and bit 4 the guard. Bits [7:5] always read 0 whatever value is written to them.
- R3: Writing bit 3 = 1 enables the watchdog at once, with no guard sequence. The count then starts from zero.
- R4: With period code c, `rst_req` fires on the 2^(BASE_EXP+c)-th tick after the last clear and not on any earlier tick.
- R5: `rst_req` is high for exactly one system clock cycle. The count restarts from zero, so the next expiry comes after another full period.
- R6: A `kick` pulse restarts the count from zero. After a kick, a full period of ticks is needed before the next expiry.
- R7: A write with bit 3 = 0 while the guard reads 0 leaves the watchdog enabled. The period field of that write still takes effect.
- R8: Writing bit 4 = 1 opens the guard. It reads 1 for exactly GUARD_CYCLES (default 4) clock cycles and then clears by itself. Any later write loads bit 4 anew.
- R9: A write with bit 3 = 0 disables the watchdog only if it lands while the guard still reads 1. While disabled, the count stays at zero and `rst_req` never fires.
- R10: If the period code is lowered below the current count, the next tick causes an expiry.
- R11: Each change of `osc_lvl`, rising or falling, counts as exactly one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| kick | input | 1 | Clear strobe that restarts the count |
| osc_lvl | input | 1 | Oscillator level; each change is one tick |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is the edge of the guard window. The disabling write must land on the last clock edge at which the guard still reads 1, or on the first edge after it closes. The bench places the second write a programmable number of edges after the guard write and tries both offsets. After each attempt it reads back the enable bit and checks that a full period of ticks brings no reset request. Lowering the period below a count already built up is the other hard case, and it is reached by a directed sequence. Random bursts of ticks and kicks are compared against a bench model of the count.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Control register field positions (read and write use the same layout)
   localparam int unsigned REG_W     = 8;
   localparam int unsigned SEL_W     = 3;
   localparam int unsigned SEL_LSB   = 0;
   localparam int unsigned EN_POS    = 3;
   localparam int unsigned GUARD_POS = 4;
   localparam int unsigned N_PERIODS = 1 << SEL_W;

   typedef struct packed {
      logic             guard;
      logic             en;
      logic [SEL_W-1:0] sel;
   } wdg_ctrl_t;

   localparam int unsigned CTRL_W = $bits(wdg_ctrl_t);

   function automatic logic [REG_W-1:0] ctrl_to_reg(input wdg_ctrl_t c);
      logic [REG_W-1:0] r;
      r = '0;
      r[SEL_LSB +: SEL_W] = c.sel;
      r[EN_POS]           = c.en;
      r[GUARD_POS]        = c.guard;
      return r;
   endfunction

endpackage

// File: rtl/wdg_tick_sync.sv
module wdg_tick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_lvl,
   output logic tick
);
   localparam int unsigned LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("wdg_tick_sync: STAGES must be at least 2");
   end

   // sh[0..STAGES-1] is the synchronizer chain, sh[STAGES] holds the previous level
   logic [LAST:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[LAST-1:0], osc_lvl};
   end

   // R11: any change of the synchronized level is one tick
   assign tick = sh[LAST] ^ sh[LAST-1];

endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
   import wdg_pkg::*;
#(
   parameter int unsigned GUARD_CYCLES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_W-1:0]     wr_data,
   output wdg_ctrl_t            ctrl
);
   localparam int unsigned GC_W = $clog2(GUARD_CYCLES + 1);
   localparam logic [GC_W-1:0] GC_LOAD = GC_W'(GUARD_CYCLES);

   if (GUARD_CYCLES < 1) begin : g_bad_guard
      $error("wdg_ctrl_reg: GUARD_CYCLES must be at least 1");
   end

   logic [GC_W-1:0]  gcnt_q;
   logic             en_q;
   logic [SEL_W-1:0] sel_q;
   logic             guard_open;
   logic             wr_en_bit;
   logic             wr_guard_bit;

   assign guard_open   = (gcnt_q != '0);
   assign wr_en_bit    = wr_data[EN_POS];
   assign wr_guard_bit = wr_data[GUARD_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         sel_q  <= '0;
         gcnt_q <= '0;
      end else if (wr_en) begin
         sel_q  <= wr_data[SEL_LSB +: SEL_W];
         // R3 set freely; R7/R9 clear only through an open guard
         en_q   <= wr_en_bit | (en_q & ~guard_open);
         // R8 guard window restarts from each write
         gcnt_q <= wr_guard_bit ? GC_LOAD : '0;
      end else if (guard_open) begin
         gcnt_q <= gcnt_q - 1'b1;
      end
   end

   assign ctrl.guard = guard_open;
   assign ctrl.en    = en_q;
   assign ctrl.sel   = sel_q;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
   import wdg_pkg::*;
#(
   parameter int unsigned BASE_EXP = 14,
   parameter int unsigned CNT_W    = BASE_EXP + 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             kick,
   input  logic [SEL_W-1:0] sel,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   if (CNT_W < BASE_EXP + N_PERIODS - 1) begin : g_bad_width
      $error("wdg_counter: CNT_W too narrow for the longest period");
   end

   // R4: terminal count for each period code, 2^(BASE_EXP+code) - 1
   logic [CNT_W-1:0] last_tab [N_PERIODS];
   for (genvar g = 0; g < N_PERIODS; g++) begin : g_tab
      assign last_tab[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
   end

   logic [CNT_W-1:0] last_sel;
   logic             at_end;

   assign last_sel = last_tab[sel];
   // R10: a count already past a lowered limit also expires
   assign at_end   = (cnt >= last_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (!run || kick) begin
            cnt <= '0;                    // R6, R9
         end else if (tick) begin
            if (at_end) begin
               cnt    <= '0;              // R5
               expire <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
   import wdg_pkg::*;
#(
   parameter int unsigned BASE_EXP     = 14,
   parameter int unsigned GUARD_CYCLES = 4,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       kick,
   input  logic       osc_lvl,
   output logic       rst_req
);
   localparam int unsigned CNT_W = BASE_EXP + N_PERIODS - 1;

   if (BASE_EXP < 1 || BASE_EXP > 40) begin : g_bad_exp
      $error("wdog_guard: BASE_EXP out of range");
   end

   wdg_ctrl_t        ctrl;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   wdg_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .osc_lvl (osc_lvl),
      .tick    (tick)
   );

   wdg_ctrl_reg #(.GUARD_CYCLES(GUARD_CYCLES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctrl    (ctrl)
   );

   wdg_counter #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl.en),
      .tick   (tick),
      .kick   (kick),
      .sel    (ctrl.sel),
      .cnt    (cnt_q),
      .expire (rst_req)
   );

   // R2: reserved bits read as zero
   assign rd_data = ctrl_to_reg(ctrl);

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
   parameter int unsigned GUARD_CYCLES = 4,
   parameter int unsigned CNT_W        = 21
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             kick,
   input logic [7:0]       rd_data,
   input logic             rst_req,
   input logic [CNT_W-1:0] cnt
);
   localparam int unsigned GL_W = $clog2(GUARD_CYCLES + 2) + 1;

   logic [GL_W-1:0] guard_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          guard_len <= '0;
      else if (wr_en)      guard_len <= '0;
      else if (rd_data[4]) guard_len <= guard_len + 1'b1;
      else                 guard_len <= '0;
   end

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:5] == 3'b000);

   // R5
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R5
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> cnt == '0);

   // R6
   kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> cnt == '0);

   // R9
   no_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(rd_data[3]));

   // R9
   guarded_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_data[3]) |-> $past(rd_data[4]));

   // R8
   guard_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      guard_len <= GL_W'(GUARD_CYCLES));

endmodule

bind wdog_guard wdg_chk #(.GUARD_CYCLES(GUARD_CYCLES), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .kick    (kick),
   .rd_data (rd_data),
   .rst_req (rst_req),
   .cnt     (cnt_q)
);

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
   localparam int BEXP = 2;
   localparam int GCYC = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       kick = 1'b0;
   logic       osc_lvl = 1'b0;
   logic       rst_req;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int run_len = 0;
   int max_run = 0;
   bit done = 1'b0;

   wdog_guard #(.BASE_EXP(BEXP), .GUARD_CYCLES(GCYC), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .kick(kick), .osc_lvl(osc_lvl), .rst_req(rst_req)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rst_req) begin
            pulses++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
         end else begin
            run_len = 0;
         end
      end
   end

   function automatic int period_of(input int code);
      return 1 << (BEXP + code);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic do_kick();
      @(negedge clk); kick = 1'b1;
      @(negedge clk); kick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); osc_lvl = ~osc_lvl;
         repeat (4) @(negedge clk);
      end
   endtask

   // open the guard, then put the disabling write k edges later
   task automatic guard_then_off(input int k);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h18;
      for (int i = 1; i < k; i++) begin
         @(negedge clk); wr_en = 1'b0;
      end
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h00;
      @(negedge clk); wr_en = 1'b0;
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int p0;
      int gl;
      int model;
      int sel;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
      chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 reserved bits, R3 immediate enable, R8 auto-clear
      reg_wr(8'hFF);
      chk(rd_data == 8'h1F, "R2 readback", rd_data, 8'h1F);
      repeat (6) @(negedge clk);
      chk(rd_data == 8'h0F, "R8 guard cleared", rd_data, 8'h0F);

      // R4/R11 period 4 ticks, both level edges count
      reg_wr(8'h08);
      do_kick();
      p0 = pulses;
      ticks(period_of(0) - 1);
      chk(pulses == p0, "R4 early", pulses - p0, 0);
      ticks(1);
      chk(pulses == p0 + 1, "R11 R4 expiry", pulses - p0, 1);
      chk(max_run == 1, "R5 width", max_run, 1);
      ticks(period_of(0) - 1);
      chk(pulses == p0 + 1, "R5 restart early", pulses - p0, 1);
      ticks(1);
      chk(pulses == p0 + 2, "R5 second expiry", pulses - p0, 2);

      // R6 kick restarts count
      reg_wr(8'h0A);
      do_kick();
      p0 = pulses;
      ticks(period_of(2) - 1);
      do_kick();
      ticks(period_of(2) - 1);
      chk(pulses == p0, "R6 kicked", pulses - p0, 0);
      ticks(1);
      chk(pulses == p0 + 1, "R6 expiry", pulses - p0, 1);

      // R7 unguarded disable ignored, period updated
      reg_wr(8'h02);
      chk(rd_data == 8'h0A, "R7 still enabled", rd_data, 8'h0A);
      reg_wr(8'h08);
      do_kick();
      p0 = pulses;
      ticks(period_of(0));
      chk(pulses == p0 + 1, "R7 period taken", pulses - p0, 1);

      // R10 lowered period below current count
      reg_wr(8'h0B);
      do_kick();
      p0 = pulses;
      ticks(20);
      reg_wr(8'h09);
      chk(pulses == p0, "R10 before tick", pulses - p0, 0);
      ticks(1);
      chk(pulses == p0 + 1, "R10 fires next tick", pulses - p0, 1);

      // R8 guard length
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h18;
      @(negedge clk); wr_en = 1'b0;
      gl = 0;
      for (int i = 0; i < 10; i++) begin
         if (rd_data[4]) gl++;
         @(negedge clk);
      end
      chk(gl == GCYC, "R8 guard cycles", gl, GCYC);

      // R9 boundary: one edge late stays enabled, last edge disables
      guard_then_off(GCYC + 1);
      chk(rd_data[3] == 1'b1, "R9 late write", rd_data[3], 1);
      guard_then_off(GCYC);
      chk(rd_data[3] == 1'b0, "R9 in-window write", rd_data[3], 0);
      p0 = pulses;
      ticks(2 * period_of(0) + 1);
      chk(pulses == p0, "R9 no request off", pulses - p0, 0);

      // R3 re-enable at once, count from zero
      reg_wr(8'h08);
      chk(rd_data[3] == 1'b1, "R3 enable", rd_data[3], 1);
      ticks(period_of(0) - 1);
      chk(pulses == p0, "R3 fresh count", pulses - p0, 0);
      ticks(1);
      chk(pulses == p0 + 1, "R3 expiry", pulses - p0, 1);

      // random ticks and kicks against a model (R4 R6)
      for (int b = 0; b < 4; b++) begin
         sel = int'($urandom_range(2, 0));
         reg_wr(8'h08 | 8'(sel));
         do_kick();
         model = 0;
         p0 = pulses;
         for (int a = 0; a < 60; a++) begin
            if ($urandom_range(9, 0) < 2) begin
               do_kick();
               model = 0;
            end else begin
               ticks(1);
               model++;
               if (model == period_of(sel)) begin
                  model = 0;
                  p0++;
               end
            end
            chk(pulses == p0, "R4 R6 random", pulses, p0);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule